// File: doc/BRIEF.md
# Event Readout Sequencer

This block runs on the acquisition controller and serves one or more front-end chips that share an open-drain service-request line. Any chip may pull the line active when it sees a hit. The sequencer then records the moment of the hit from a free-running counter. It also takes over the request line, which keeps the chips from accepting further triggers while their stored results are read.

While holding the line, the sequencer waits a fixed number of cycles so the analog peak detectors can reach their maxima. It then toggles a shared serial clock and shifts in one data bit per chip on every pulse, with all chips in parallel. When the last bit has arrived it releases the line and presents the timestamp and the collected words for one cycle. Finally it pulses a shared chip reset, which clears the front-ends before the next event.

Top module: `evt_readout_seq`

## Requirements
- R1: While `rstN` is low and in the cycle after its release, `srqDrive`, `chipClk`, `chipReset` and `evtValid` are all 0.
- R2: In the idle state, `srqIn` = 1 starts an event only if `srqIn` has been sampled 0 in the idle state since reset or since the last event. `srqDrive` goes to 1 in the cycle after the accepting edge.
- R3: `evtStamp` is the value, at the accepting edge, of a STAMP_BITS-wide counter that clears on reset, adds one every cycle and wraps from all-ones to zero.
- R4: `srqDrive` stays 1 without a break for 1 + SETTLE_CYCLES + 2·CHIP_BITS cycles per event.
- R5: The first `chipClk` high cycle comes exactly SETTLE_CYCLES + 1 cycles after the first `srqDrive` high cycle.
- R6: Each readout gives CHIP_BITS clock pulses. Each pulse is one cycle with `chipClk` = 1 followed by one cycle with `chipClk` = 0. Every `chipData` bit is sampled at the clock edge that ends a high cycle.
- R7: Chip c fills `evtData[c*CHIP_BITS +: CHIP_BITS]`, and the first bit received from a chip ends up as the MSB of that slice.
- R8: In the cycle after the last low clock cycle, `srqDrive` is 0 and `evtValid` is 1 for exactly that one cycle, with `evtStamp` and `evtData` valid.
- R9: `chipReset` is 1 for exactly RESET_CYCLES (default 4) cycles right after the valid cycle, and is 0 at all other times.
- R10: Changes on `srqIn` while an event is being read out do not affect the timing, the stamp or the data.

Parameters: NUM_CHIPS (2), WORD_BITS (8), WORDS_PER_CHIP (2), STAMP_BITS (32), SETTLE_CYCLES (200), RESET_CYCLES (4). CHIP_BITS is WORD_BITS·WORDS_PER_CHIP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srqIn | input | 1 | Sampled level of the shared request line, 1 = active |
| srqDrive | output | 1 | Enable for driving the request line active |
| chipClk | output | 1 | Serial conversion and readout clock to the chips |
| chipReset | output | 1 | Reset pulse to the chips |
| chipData | input | NUM_CHIPS | Serial data, one bit per chip |
| evtValid | output | 1 | One-cycle strobe marking a finished event |
| evtStamp | output | STAMP_BITS | Event timestamp |
| evtData | output | NUM_CHIPS·CHIP_BITS | Collected words, chip 0 in the low slice |

## Verification
Two functions can meet in one cycle: the last cycle of the chip reset pulse and detection of a new request. A chip may keep the line active through the reset and into idle. The bench provokes this by holding `srqIn` at 1 through the whole reset pulse and into idle. It then checks that `srqDrive` stays 0 until `srqIn` has been 0 for one idle cycle, and that the event starts on the very next active sample after that.

// File: rtl/evt_readout_seq_pkg.sv
package evt_readout_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_SETTLE,
    ST_CLOCKING,
    ST_RELEASE,
    ST_RESET
  } seqState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureStamp;
    logic clearShift;
    logic shiftEn;
  } dpCtrl_t;

endpackage

// File: rtl/evt_readout_seq_ctrl.sv
module evt_readout_seq_ctrl
  import evt_readout_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 200,
  parameter int CHIP_BITS     = 16,
  parameter int RESET_CYCLES  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    srqIn,
  output logic    srqDrive,
  output logic    chipClk,
  output logic    chipReset,
  output logic    evtValid,
  output dpCtrl_t dpCtrl
);

  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam int BIT_W    = $clog2(CHIP_BITS + 1);
  localparam int RST_W    = $clog2(RESET_CYCLES + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_CYCLES - 1);
  localparam logic [BIT_W-1:0]    BIT_LAST    = BIT_W'(CHIP_BITS - 1);
  localparam logic [RST_W-1:0]    RST_LAST    = RST_W'(RESET_CYCLES - 1);

  seqState_e            state;
  logic                 armed;
  logic                 phase;
  logic [SETTLE_W-1:0]  settleCnt;
  logic [BIT_W-1:0]     bitCnt;
  logic [RST_W-1:0]     rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      phase     <= 1'b0;
      settleCnt <= '0;
      bitCnt    <= '0;
      rstCnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!srqIn) begin
            armed <= 1'b1;
          end else if (armed) begin
            armed <= 1'b0;
            state <= ST_CAPTURE;
          end
        end
        ST_CAPTURE: begin
          settleCnt <= '0;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settleCnt == SETTLE_LAST) begin
            bitCnt <= '0;
            phase  <= 1'b0;
            state  <= ST_CLOCKING;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_CLOCKING: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bitCnt == BIT_LAST) begin
              state <= ST_RELEASE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_RELEASE: begin
          rstCnt <= '0;
          state  <= ST_RESET;
        end
        ST_RESET: begin
          if (rstCnt == RST_LAST) begin
            state <= ST_IDLE;
          end else begin
            rstCnt <= rstCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    srqDrive  = (state == ST_CAPTURE) || (state == ST_SETTLE) || (state == ST_CLOCKING);
    chipClk   = (state == ST_CLOCKING) && !phase;
    chipReset = (state == ST_RESET);
    evtValid  = (state == ST_RELEASE);
    dpCtrl.captureStamp = (state == ST_IDLE) && srqIn && armed;
    dpCtrl.clearShift   = (state == ST_CAPTURE);
    dpCtrl.shiftEn      = (state == ST_CLOCKING) && !phase;
  end

endmodule

// File: rtl/evt_readout_seq_dp.sv
module evt_readout_seq_dp
  import evt_readout_seq_pkg::*;
#(
  parameter int NUM_CHIPS  = 2,
  parameter int CHIP_BITS  = 16,
  parameter int STAMP_BITS = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtrl_t                        dpCtrl,
  input  logic [NUM_CHIPS-1:0]           chipData,
  output logic [STAMP_BITS-1:0]          evtStamp,
  output logic [NUM_CHIPS*CHIP_BITS-1:0] evtData
);

  logic [STAMP_BITS-1:0] tsCount;
  logic [STAMP_BITS-1:0] stampReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsCount  <= '0;
      stampReg <= '0;
    end else begin
      tsCount <= tsCount + 1'b1;
      if (dpCtrl.captureStamp) stampReg <= tsCount;
    end
  end

  assign evtStamp = stampReg;

  for (genvar g = 0; g < NUM_CHIPS; g++) begin : gChip
    logic [CHIP_BITS-1:0] shiftReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else if (dpCtrl.clearShift) begin
        shiftReg <= '0;
      end else if (dpCtrl.shiftEn) begin
        shiftReg <= {shiftReg[CHIP_BITS-2:0], chipData[g]};
      end
    end
    assign evtData[g*CHIP_BITS +: CHIP_BITS] = shiftReg;
  end

endmodule

// File: rtl/evt_readout_seq.sv
module evt_readout_seq
  import evt_readout_seq_pkg::*;
#(
  parameter int NUM_CHIPS      = 2,
  parameter int WORD_BITS      = 8,
  parameter int WORDS_PER_CHIP = 2,
  parameter int STAMP_BITS     = 32,
  parameter int SETTLE_CYCLES  = 200,
  parameter int RESET_CYCLES   = 4,
  localparam int CHIP_BITS     = WORD_BITS * WORDS_PER_CHIP,
  localparam int DATA_W        = NUM_CHIPS * CHIP_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  srqIn,
  output logic                  srqDrive,
  output logic                  chipClk,
  output logic                  chipReset,
  input  logic [NUM_CHIPS-1:0]  chipData,
  output logic                  evtValid,
  output logic [STAMP_BITS-1:0] evtStamp,
  output logic [DATA_W-1:0]     evtData
);

  dpCtrl_t dpCtrl;

  evt_readout_seq_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CHIP_BITS    (CHIP_BITS),
    .RESET_CYCLES (RESET_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srqIn    (srqIn),
    .srqDrive (srqDrive),
    .chipClk  (chipClk),
    .chipReset(chipReset),
    .evtValid (evtValid),
    .dpCtrl   (dpCtrl)
  );

  evt_readout_seq_dp #(
    .NUM_CHIPS (NUM_CHIPS),
    .CHIP_BITS (CHIP_BITS),
    .STAMP_BITS(STAMP_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .chipData(chipData),
    .evtStamp(evtStamp),
    .evtData (evtData)
  );

endmodule

// File: rtl/evt_readout_seq_chk.sv
module evt_readout_seq_chk #(
  parameter int RESET_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic srqIn,
  input logic srqDrive,
  input logic chipClk,
  input logic chipReset,
  input logic evtValid
);

  localparam int LEN_W = $clog2(RESET_CYCLES + 2);
  localparam logic [LEN_W-1:0] LEN_EXP = LEN_W'(RESET_CYCLES);

  logic [LEN_W-1:0] rstLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstLen <= '0;
    else if (chipReset) rstLen <= rstLen + 1'b1;
    else rstLen <= '0;
  end

  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srqDrive) |-> $past(srqIn)); // R2
  AST_CLK_UNDER_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    chipClk |-> srqDrive); // R4
  AST_CLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    chipClk |=> !chipClk); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid); // R8
  AST_VALID_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> !srqDrive); // R8
  AST_RESET_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> chipReset); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    chipReset |-> !srqDrive && !chipClk); // R9
  AST_RESET_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chipReset) |-> rstLen == LEN_EXP); // R9
  AST_RESET_MAX: assert property (@(posedge clk) disable iff (!rstN)
    chipReset |-> rstLen < LEN_EXP); // R9

endmodule

bind evt_readout_seq evt_readout_seq_chk #(.RESET_CYCLES(RESET_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .srqIn    (srqIn),
  .srqDrive (srqDrive),
  .chipClk  (chipClk),
  .chipReset(chipReset),
  .evtValid (evtValid)
);

// File: tb/evt_readout_seq_tb.sv
module evt_readout_seq_tb;

  localparam int NCH    = 2;
  localparam int CBITS  = 16;
  localparam int DW     = NCH * CBITS;
  localparam int SBITS  = 10;
  localparam int SETTLE = 200;
  localparam int RSTC   = 4;
  localparam int NVEC   = 6;

  // {idle gap before request, toggle srqIn during readout, data}
  localparam logic [48:0] VEC [NVEC] = '{
    {16'd1,  1'b0, 32'hA5C3_0F81},
    {16'd3,  1'b1, 32'hFFFF_0000},
    {16'd7,  1'b0, 32'h0000_FFFF},
    {16'd2,  1'b1, 32'h8001_7FFE},
    {16'd40, 1'b0, 32'h1234_5678},
    {16'd5,  1'b0, 32'hDEAD_BEEF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srqIn = 1'b0;
  logic [NCH-1:0] chipData = '0;
  logic srqDrive, chipClk, chipReset, evtValid;
  logic [SBITS-1:0] evtStamp;
  logic [DW-1:0] evtData;
  logic [SBITS-1:0] tbCnt;

  int total = 0;
  int fails = 0;
  logic [SBITS-1:0] prevStamp = '0;
  int wraps = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) tbCnt <= '0;
    else tbCnt <= tbCnt + 1'b1;

  evt_readout_seq #(
    .NUM_CHIPS(NCH), .WORD_BITS(8), .WORDS_PER_CHIP(2),
    .STAMP_BITS(SBITS), .SETTLE_CYCLES(SETTLE), .RESET_CYCLES(RSTC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .srqIn(srqIn), .srqDrive(srqDrive),
    .chipClk(chipClk), .chipReset(chipReset), .chipData(chipData),
    .evtValid(evtValid), .evtStamp(evtStamp), .evtData(evtData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  function automatic logic [NCH-1:0] bitsAt(input logic [DW-1:0] d, input int b);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = d[c*CBITS + CBITS - 1 - b];
    return r;
  endfunction

  // One full event; holdHigh keeps srqIn active after the event ends
  task automatic runEvent(input int gap, input bit toggle, input logic [DW-1:0] d, input bit holdHigh);
    logic [SBITS-1:0] expStamp;
    int k;
    int driveCnt;
    int pulses;
    bit driveGap;
    bit clkShape;
    srqIn = 1'b0;
    repeat (gap) @(negedge clk);
    srqIn = 1'b1;
    expStamp = tbCnt;
    chipData = bitsAt(d, 0);
    @(negedge clk);
    chk(srqDrive == 1'b1, "R2 drive after request", 64'(srqDrive), 64'd1);
    driveCnt = 1;
    driveGap = 1'b0;
    k = 0;
    while (!chipClk && k < SETTLE + 10) begin
      @(negedge clk);
      k++;
      if (toggle) srqIn = ~srqIn;
      if (srqDrive) driveCnt++; else driveGap = 1'b1;
    end
    chk(k == SETTLE + 1, "R5 settle length", 64'(k), 64'(SETTLE + 1));
    pulses = 0;
    clkShape = 1'b1;
    for (int b = 0; b < CBITS; b++) begin
      if (chipClk) pulses++; else clkShape = 1'b0;
      @(negedge clk);
      if (toggle) srqIn = ~srqIn;
      if (srqDrive) driveCnt++; else driveGap = 1'b1;
      if (chipClk) clkShape = 1'b0;
      if (b < CBITS - 1) chipData = bitsAt(d, b + 1);
      @(negedge clk);
      if (toggle) srqIn = ~srqIn;
      if (b < CBITS - 1) begin
        if (srqDrive) driveCnt++; else driveGap = 1'b1;
      end
    end
    chk(pulses == CBITS && clkShape, "R6 clock pulses", 64'(pulses), 64'(CBITS));
    chk(!driveGap && driveCnt == 1 + SETTLE + 2*CBITS, "R4 drive span", 64'(driveCnt), 64'(1 + SETTLE + 2*CBITS));
    if (toggle) chk(!driveGap, "R10 srqIn ignored", 64'(driveGap), 64'd0);
    chk(evtValid && !srqDrive, "R8 release and valid", {62'd0, evtValid, srqDrive}, 64'h2);
    chk(evtData == d, "R7 data", 64'(evtData), 64'(d));
    chk(evtStamp == expStamp, "R3 stamp", 64'(evtStamp), 64'(expStamp));
    if (evtStamp < prevStamp) wraps++;
    prevStamp = evtStamp;
    srqIn = holdHigh;
    k = 0;
    @(negedge clk);
    chk(!evtValid, "R8 valid single cycle", 64'(evtValid), 64'd0);
    while (chipReset && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(k == RSTC, "R9 reset length", 64'(k), 64'(RSTC));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!srqDrive && !chipClk && !chipReset && !evtValid, "R1 in reset",
        {60'd0, srqDrive, chipClk, chipReset, evtValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!srqDrive && !chipClk && !chipReset && !evtValid, "R1 after reset",
        {60'd0, srqDrive, chipClk, chipReset, evtValid}, 64'd0);

    for (int i = 0; i < NVEC; i++)
      runEvent(int'(VEC[i][48:33]), VEC[i][32], VEC[i][31:0], 1'b0);
    chk(wraps > 0, "R3 stamp wrap", 64'(wraps), 64'd1);

    // Request still active when reset ends: must not restart
    runEvent(2, 1'b0, 32'h0F0F_F0F0, 1'b1);
    begin
      bit sawDrive = 1'b0;
      repeat (12) begin
        @(negedge clk);
        if (srqDrive) sawDrive = 1'b1;
      end
      chk(!sawDrive, "R2 no restart without idle gap", 64'(sawDrive), 64'd0);
    end
    runEvent(1, 1'b0, 32'h3C3C_C3C3, 1'b0);

    // Request held through reset from the start of a run
    srqIn = 1'b1;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    begin
      bit sawDrive = 1'b0;
      repeat (6) begin
        @(negedge clk);
        if (srqDrive) sawDrive = 1'b1;
      end
      chk(!sawDrive, "R2 not armed after reset", 64'(sawDrive), 64'd0);
    end
    runEvent(1, 1'b1, 32'h5555_AAAA, 1'b0);
    finishRun();
  end

endmodule